// File: doc/BRIEF.md
# Integer Remainder Unit

This block computes the remainder of operand A divided by operand B for a 64-bit integer datapath. Two select pins choose among four operation types: signed or unsigned, each on the low 32-bit word or on the full 64-bit doubleword. The remainder follows truncating division, so a signed result carries the sign of the dividend. A word result is zero-extended into the 64-bit result.

Operands enter through a valid/ready handshake. `in_ready` is high only while the unit is idle. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. While a division runs, `in_ready` stays low, and any `in_valid` seen in that time is not taken and has no effect. The output side has no back-pressure. `done` pulses for one cycle, and `result` holds its value until the next completion.

The core is an iterative radix-2 restoring divider that works on operand magnitudes. A set of corner cases is detected on acceptance and answered with zero at once: a zero divisor, the most negative dividend over minus one, and minus one over plus or minus one. For these the iterative loop is skipped.

Top module: `rem_unit`

## Requirements
- R1: When the divisor is zero (the low 32 bits in word mode, all 64 bits in doubleword mode), the result is zero in all four modes, whatever the dividend.
- R2: In signed mode, the most negative dividend (0x80000000 in word mode, 0x8000000000000000 in doubleword mode) divided by minus one gives zero.
- R3: In signed mode, a dividend of minus one with a divisor of plus one or minus one gives zero, never an all-ones value.
- R4: A request that hits R1, R2 or R3 is answered with `done` high in the cycle right after the accepting edge, with `result` equal to zero.
- R5: A signed remainder takes the sign of the dividend. Examples: -5 rem 3 = -2, 5 rem -3 = 2, and in word mode -2147483648 rem -2147483647 = -1.
- R6: An unsigned remainder treats both operands as magnitudes. Example: 0xFFFFFFF8 rem 0xFFFFFFF9 = 0xFFFFFFF8 in word mode. A dividend smaller than the divisor comes back unchanged.
- R7: Word modes ignore bits 63:32 of both operands, and a word result has bits 63:32 at zero. Example: a signed word -1 rem 0x12345678 gives 0x00000000FFFFFFFF.
- R8: Any other request completes with `done` high 33 edges (word) or 65 edges (doubleword) after the accepting edge. `in_ready` is low from the edge after acceptance until `done` is raised.
- R9: `in_valid` while `in_ready` is low is not taken: it alters neither the result nor the timing of the running operation, and it produces no extra `done`.
- R10: `done` is a single-cycle pulse unless a new request is taken in that cycle. `result` changes only in the cycle where `done` is raised.
- R11: A synchronous active-high `rst` makes the unit idle: `in_ready` high, `done` low and `result` zero, even in the middle of a division. An interrupted division never completes.
- R12: `in_ready` is high in the cycle where `done` is raised, so a new request can be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair and mode are valid |
| in_ready | output | 1 | Unit is idle and takes a request |
| opa | input | 64 | Dividend |
| opb | input | 64 | Divisor |
| is_signed | input | 1 | 1: signed operands, 0: unsigned |
| is_word | input | 1 | 1: low 32-bit word, 0: full doubleword |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Remainder, held until the next completion |

## Verification
Completion and acceptance can occur in the same cycle. When `done` is raised, `in_ready` is already high again, so a new request can be taken on that very edge. The bench waits for `done` and drives the next request in the same cycle, using both a normal and a forced-zero second request. It then judges the first result at that point, checks that the first pulse does not stretch, and confirms the second result arrives with its own full latency. It also holds `in_valid` against a busy unit and confirms the running result and its latency stay unaltered.

// File: rtl/rem_pkg.sv
package rem_pkg;
  localparam int unsigned REM_XLEN = 64;

  typedef struct packed {
    logic sgn;
    logic word;
  } rem_mode_t;
endpackage

// File: rtl/rem_special.sv
module rem_special #(
  parameter int unsigned XLEN = rem_pkg::REM_XLEN
) (
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  input  rem_pkg::rem_mode_t mode,
  output logic              force_zero
);
  localparam int unsigned HALF = XLEN / 2;

  logic [HALF-1:0] a_lo, b_lo;
  logic zero_w, zero_d, min_w, min_d, am1_w, am1_d, bm1_w, bm1_d, bp1_w, bp1_d;
  logic sgn_hit_w, sgn_hit_d;

  always_comb begin
    a_lo   = opa[HALF-1:0];
    b_lo   = opb[HALF-1:0];
    zero_w = (b_lo == '0);
    zero_d = (opb == '0);
    min_w  = (a_lo == {1'b1, {(HALF-1){1'b0}}});
    min_d  = (opa  == {1'b1, {(XLEN-1){1'b0}}});
    am1_w  = &a_lo;
    am1_d  = &opa;
    bm1_w  = &b_lo;
    bm1_d  = &opb;
    bp1_w  = (b_lo == HALF'(1));
    bp1_d  = (opb  == XLEN'(1));
    sgn_hit_w = (min_w & bm1_w) | (am1_w & (bm1_w | bp1_w));
    sgn_hit_d = (min_d & bm1_d) | (am1_d & (bm1_d | bp1_d));
    if (mode.word) force_zero = zero_w | (mode.sgn & sgn_hit_w);
    else           force_zero = zero_d | (mode.sgn & sgn_hit_d);
  end
endmodule

// File: rtl/rem_prep.sv
module rem_prep #(
  parameter int unsigned XLEN = rem_pkg::REM_XLEN,
  parameter int unsigned CW   = $clog2(XLEN + 1)
) (
  input  logic [XLEN-1:0]    opa,
  input  logic [XLEN-1:0]    opb,
  input  rem_pkg::rem_mode_t mode,
  output logic [XLEN-1:0]    dividend,
  output logic [XLEN-1:0]    divisor,
  output logic               neg_dvd,
  output logic [CW-1:0]      iters
);
  localparam int unsigned HALF = XLEN / 2;

  logic [HALF-1:0] a_lo, b_lo, am_w, bm_w;
  logic [XLEN-1:0] am_d, bm_d;
  logic an_w, bn_w, an_d, bn_d;

  always_comb begin
    a_lo = opa[HALF-1:0];
    b_lo = opb[HALF-1:0];
    an_w = mode.sgn & a_lo[HALF-1];
    bn_w = mode.sgn & b_lo[HALF-1];
    an_d = mode.sgn & opa[XLEN-1];
    bn_d = mode.sgn & opb[XLEN-1];
    am_w = an_w ? -a_lo : a_lo;
    bm_w = bn_w ? -b_lo : b_lo;
    am_d = an_d ? -opa : opa;
    bm_d = bn_d ? -opb : opb;
    if (mode.word) begin
      dividend = {am_w, {HALF{1'b0}}};
      divisor  = {{HALF{1'b0}}, bm_w};
      neg_dvd  = an_w;
      iters    = CW'(HALF);
    end else begin
      dividend = am_d;
      divisor  = bm_d;
      neg_dvd  = an_d;
      iters    = CW'(XLEN);
    end
  end
endmodule

// File: rtl/rem_core.sv
module rem_core #(
  parameter int unsigned XLEN = rem_pkg::REM_XLEN,
  parameter int unsigned CW   = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [XLEN-1:0] dividend,
  input  logic [XLEN-1:0] divisor,
  input  logic [CW-1:0]   iters,
  output logic            fin,
  output logic [XLEN-1:0] rem
);
  logic [XLEN-1:0] acc, dq, dvs;
  logic [CW-1:0]   cnt;
  logic [XLEN:0]   shifted;
  logic            fits;

  always_comb begin
    shifted = {acc, dq[XLEN-1]};
    fits    = (shifted >= {1'b0, dvs});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      dq  <= '0;
      dvs <= '0;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        acc <= '0;
        dq  <= dividend;
        dvs <= divisor;
        cnt <= iters;
      end else if (cnt != '0) begin
        acc <= fits ? XLEN'(shifted - {1'b0, dvs}) : shifted[XLEN-1:0];
        dq  <= dq << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) fin <= 1'b1;
      end
    end
  end

  assign rem = acc;
endmodule

// File: rtl/rem_unit.sv
module rem_unit #(
  parameter int unsigned XLEN = rem_pkg::REM_XLEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic            is_signed,
  input  logic            is_word,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int unsigned HALF = XLEN / 2;
  localparam int unsigned CW   = $clog2(XLEN + 1);

  rem_pkg::rem_mode_t mode;
  logic busy, accept, force_zero, neg_dvd, neg_q, word_q, core_fin;
  logic [XLEN-1:0] dividend, divisor, core_rem, signed_rem, fmt;
  logic [CW-1:0] iters;

  assign mode.sgn  = is_signed;
  assign mode.word = is_word;
  assign in_ready  = ~busy;
  assign accept    = in_valid & ~busy;

  rem_special #(.XLEN(XLEN)) u_special (
    .opa(opa), .opb(opb), .mode(mode), .force_zero(force_zero));

  rem_prep #(.XLEN(XLEN), .CW(CW)) u_prep (
    .opa(opa), .opb(opb), .mode(mode), .dividend(dividend),
    .divisor(divisor), .neg_dvd(neg_dvd), .iters(iters));

  rem_core #(.XLEN(XLEN), .CW(CW)) u_core (
    .clk(clk), .rst(rst), .load(accept & ~force_zero), .dividend(dividend),
    .divisor(divisor), .iters(iters), .fin(core_fin), .rem(core_rem));

  always_comb begin
    signed_rem = neg_q ? -core_rem : core_rem;
    fmt = word_q ? {{HALF{1'b0}}, signed_rem[HALF-1:0]} : signed_rem;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      neg_q  <= 1'b0;
      word_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        neg_q  <= neg_dvd;
        word_q <= is_word;
        if (force_zero) begin
          done   <= 1'b1;
          result <= '0;
        end else begin
          busy <= 1'b1;
        end
      end
      if (core_fin) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= fmt;
      end
    end
  end
endmodule

// File: rtl/rem_unit_chk.sv
module rem_unit_chk #(
  parameter int unsigned XLEN = rem_pkg::REM_XLEN
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [XLEN-1:0] opa,
  input logic [XLEN-1:0] opb,
  input logic            is_signed,
  input logic            is_word,
  input logic            done,
  input logic [XLEN-1:0] result
);
  localparam int unsigned HALF = XLEN / 2;

  logic take, zdiv, min_m1, m1_pm1, spec, word_seen;

  always_comb begin
    take = in_valid & in_ready;
    if (is_word) begin
      zdiv   = (opb[HALF-1:0] == '0);
      min_m1 = (opa[HALF-1:0] == {1'b1, {(HALF-1){1'b0}}}) & (&opb[HALF-1:0]);
      m1_pm1 = (&opa[HALF-1:0]) & ((&opb[HALF-1:0]) | (opb[HALF-1:0] == HALF'(1)));
    end else begin
      zdiv   = (opb == '0);
      min_m1 = (opa == {1'b1, {(XLEN-1){1'b0}}}) & (&opb);
      m1_pm1 = (&opa) & ((&opb) | (opb == XLEN'(1)));
    end
    spec = zdiv | (is_signed & (min_m1 | m1_pm1));
  end

  always_ff @(posedge clk) begin
    if (rst) word_seen <= 1'b0;
    else if (take) word_seen <= is_word;
  end

  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    take && zdiv |=> done && (result == '0)); // R1
  AST_SPECIAL_FAST: assert property (@(posedge clk) disable iff (rst)
    take && spec |=> done && (result == '0)); // R4
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    take && !spec |=> !in_ready && !done); // R8
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    done && word_seen |-> (result[XLEN-1:HALF] == '0)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(result) || done); // R10
  AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> in_ready); // R12
  AST_PULSE: assert property (@(posedge clk) disable iff (rst)
    done && !take |=> !done); // R10
endmodule

bind rem_unit rem_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .opa(opa), .opb(opb), .is_signed(is_signed), .is_word(is_word),
  .done(done), .result(result));

// File: tb/rem_unit_tb_top.sv
module rem_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [63:0] opa = '0, opb = '0;
  logic is_signed = 1'b0, is_word = 1'b0;
  logic done;
  logic [63:0] result;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rem_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .is_signed(is_signed), .is_word(is_word),
    .done(done), .result(result));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_spec(input logic [63:0] a, input logic [63:0] b,
                                 input bit s, input bit w);
    logic [31:0] a32, b32;
    a32 = a[31:0];
    b32 = b[31:0];
    if (w) return (b32 == 0) || (s && ((a32 == 32'h8000_0000 && b32 == '1) ||
                  (a32 == '1 && (b32 == '1 || b32 == 32'd1))));
    return (b == 0) || (s && ((a == 64'h8000_0000_0000_0000 && b == '1) ||
                  (a == '1 && (b == '1 || b == 64'd1))));
  endfunction

  function automatic logic [63:0] ref_rem(input logic [63:0] a, input logic [63:0] b,
                                          input bit s, input bit w);
    int r32;
    longint r64;
    if (is_spec(a, b, s, w)) return '0;
    if (w) begin
      if (s) begin
        r32 = int'(a[31:0]) % int'(b[31:0]);
        return {32'd0, 32'(r32)};
      end
      return {32'd0, a[31:0] % b[31:0]};
    end
    if (s) begin
      r64 = longint'(a) % longint'(b);
      return 64'(r64);
    end
    return a % b;
  endfunction

  // at a negedge: present request, let one edge take it, withdraw
  task automatic start_op(input logic [63:0] a, input logic [63:0] b,
                          input bit s, input bit w);
    opa = a; opb = b; is_signed = s; is_word = w; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_done(input int n0, input logic [63:0] exp, input int lat,
                           input string req);
    int n = n0;
    while (!done && n < 100) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1 && n == lat, {req, " latency"}, 64'(n), 64'(lat));
    chk(result === exp, req, result, exp);
  endtask

  task automatic do_op(input logic [63:0] a, input logic [63:0] b, input bit s,
                       input bit w, input string req);
    logic [63:0] e;
    int lat;
    e = ref_rem(a, b, s, w);
    lat = is_spec(a, b, s, w) ? 0 : (w ? 33 : 65);
    start_op(a, b, s, w);
    wait_done(0, e, lat, req);
    @(negedge clk);
    chk(done === 1'b0 && result === e, "R10 pulse/hold", {63'd0, done}, 64'd0);
  endtask

  function automatic logic [63:0] pick();
    case ($urandom % 6)
      0: return 64'($signed(int'($urandom % 13) - 6));
      1: return 64'h8000_0000_0000_0000 + 64'($urandom % 8);
      2: return 64'h7FFF_FFFF_FFFF_FFF8 + 64'($urandom % 8);
      3: return {$urandom, $urandom};
      4: return {$urandom, 32'h8000_0000 + ($urandom % 8)};
      default: return {$urandom, 32'hFFFF_FFF8 + ($urandom % 8)};
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1 && done === 1'b0 && result === '0, "R11 reset state",
        result, 64'd0);

    // R1 zero divisor in all four modes
    do_op(64'h1234_5678_9ABC_DEF0, 64'h0, 1'b1, 1'b0, "R1 sd");
    do_op(64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0, 1'b0, "R1 ud");
    do_op(64'hFFFF_FFFF_8000_0001, 64'h5555_0000_0000_0000, 1'b1, 1'b1, "R1 sw");
    do_op(64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, "R1 uw");
    // R2, R3 forced zero with R4 latency
    do_op(64'h8000_0000_0000_0000, '1, 1'b1, 1'b0, "R2 sd");
    do_op(64'hABCD_0000_8000_0000, 64'h0000_0001_FFFF_FFFF, 1'b1, 1'b1, "R2 sw");
    do_op('1, 64'd1, 1'b1, 1'b0, "R3 sd +1");
    do_op('1, '1, 1'b1, 1'b0, "R3 sd -1");
    do_op(64'h0000_0000_FFFF_FFFF, 64'd1, 1'b1, 1'b1, "R3 sw +1");
    do_op(64'h0000_0000_FFFF_FFFF, 64'h7777_7777_FFFF_FFFF, 1'b1, 1'b1, "R4 sw -1");
    // R5 sign of dividend
    do_op(-64'sd5, 64'd3, 1'b1, 1'b0, "R5 -5 rem 3");
    do_op(64'd5, -64'sd3, 1'b1, 1'b0, "R5 5 rem -3");
    do_op(64'h0000_0000_8000_0000, 64'h0000_0000_8000_0001, 1'b1, 1'b1, "R5 word min");
    // R6 unsigned
    do_op(64'hFFFF_FFF8, 64'hFFFF_FFF9, 1'b0, 1'b1, "R6 uw");
    do_op(64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFF9, 1'b0, 1'b0, "R6 ud");
    do_op(64'd7, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b0, "R6 small dividend");
    // R7 word: upper bits ignored, zero extension
    do_op(64'hDEAD_BEEF_FFFF_FFFF, 64'hF00D_0000_1234_5678, 1'b1, 1'b1, "R7 -1 word");
    do_op(64'h1111_1111_0000_0064, 64'h2222_2222_0000_0007, 1'b0, 1'b1, "R7 junk upper");

    // R9: requests against a busy unit are not taken
    begin
      logic [63:0] e9;
      e9 = ref_rem(64'h0123_4567_89AB_CDEF, 64'd1000, 1'b0, 1'b0);
      start_op(64'h0123_4567_89AB_CDEF, 64'd1000, 1'b0, 1'b0);
      for (int k = 0; k < 10; k++) begin
        opa = {$urandom, $urandom}; opb = 64'd0; is_word = 1'b1; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (k == 3) chk(in_ready === 1'b0, "R8 ready low while busy",
                        {63'd0, in_ready}, 64'd0);
      end
      in_valid = 1'b0;
      wait_done(10, e9, 65, "R9 busy request ignored");
      @(negedge clk);
      chk(done === 1'b0, "R9 no extra done", {63'd0, done}, 64'd0);
    end

    // R12: accept the next request in the done cycle
    begin
      logic [63:0] e1, e2;
      e1 = ref_rem(64'h0000_0000_0001_0000, 64'd9, 1'b0, 1'b1);
      e2 = ref_rem(-64'sd1000, 64'd7, 1'b1, 1'b0);
      start_op(64'h0000_0000_0001_0000, 64'd9, 1'b0, 1'b1);
      wait_done(0, e1, 33, "R12 first");
      start_op(-64'sd1000, 64'd7, 1'b1, 1'b0);
      chk(done === 1'b0, "R12 first pulse ended", {63'd0, done}, 64'd0);
      wait_done(0, e2, 65, "R12 second");
      start_op(64'd77, 64'd0, 1'b0, 1'b0);
      chk(done === 1'b1 && result === '0, "R12 special in done cycle", result, 64'd0);
      @(negedge clk);
    end

    // R11: reset in the middle of a division
    start_op(64'h0FFF_0000_0000_1234, 64'd3, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk(in_ready === 1'b1 && done === 1'b0 && result === '0, "R11 mid-run reset",
        result, 64'd0);
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      chk(!seen, "R11 aborted op silent", {63'd0, seen}, 64'd0);
    end

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      bit s, w;
      s = 1'($urandom);
      w = 1'($urandom);
      do_op(pick(), ($urandom % 10 == 0) ? 64'd0 : pick(), s, w, "R5/R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule